// File: doc/BRIEF.md
# Backward defect persistence filter

This block filters a one-bit backward defect indication that arrives once per frame. The caller presents the bit together with a frame strobe. The block accepts a new value only when the same bit has been seen on a fixed number of consecutive frames (five by default). It keeps the accepted value as a live status output.

Each time the live value toggles, a sticky change flag is raised. Software clears the flag by writing a one to it, and the flag is masked into a level interrupt.

A group of upstream alarm flags suspends the filter while any of them is active: loss of signal, loss of frame, locked, open connection and alarm indication. Out-of-frame joins this group only when software enables it. While the filter is suspended, frames are ignored and the run count is cleared, so a fresh run starts with the first frame after the alarms drop. Frame alignment and overhead extraction are done elsewhere.

Top module: `bdf_filter`

## Requirements
- R1: The live output `bdi_live` takes a new value only at the clock edge that samples the fifth consecutive frame strobe (`PERSIST_FRAMES`) carrying that value with no pause between. Cycles without a strobe neither count nor break a run.
- R2: A strobed bit that differs from the current candidate starts a new run of length one, with that bit as the candidate.
- R3: `bdi_live` keeps its last accepted value between acceptances and throughout a pause. It is 0 after reset.
- R4: `cos_sticky` goes to 1 on the same clock edge at which `bdi_live` changes. If a clear request arrives on that same cycle, the set wins.
- R5: A write to address 1 with data bit 0 at 1 clears `cos_sticky`. Writes to other addresses, or with bit 0 at 0, leave it unchanged.
- R6: `cos_irq` equals `cos_sticky` AND the interrupt enable on every cycle. The interrupt enable is bit 0 of the control register at address 0.
- R7: While any of `alm_los`, `alm_lof`, `alm_lck`, `alm_oci` or `alm_ais` is 1, strobes are ignored and the run count is zero. After the pause, counting restarts from zero with the next strobed bit.
- R8: `alm_oof` pauses the filter as in R7 only while bit 1 of the control register at address 0 is 1. Otherwise it has no effect.
- R9: After reset, `bdi_live`, `cos_sticky` and `cos_irq` are 0, and both control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| bdi_bit | input | 1 | Backward defect bit of the current frame, valid with `frame_stb` |
| alm_oof | input | 1 | Out-of-frame alarm, gated by control bit 1 |
| alm_lof | input | 1 | Loss-of-frame alarm |
| alm_los | input | 1 | Loss-of-signal alarm |
| alm_lck | input | 1 | Locked maintenance signal detected |
| alm_oci | input | 1 | Open connection indication detected |
| alm_ais | input | 1 | Alarm indication signal detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 is control, 1 is status clear |
| reg_wdata | input | DATA_W | Write data |
| bdi_live | output | 1 | Last accepted backward defect value |
| cos_sticky | output | 1 | Sticky change-of-state flag |
| cos_irq | output | 1 | Masked interrupt |

## Verification
Some rules are checked by the assertions on every cycle. The live value may change only after an unpaused strobe, and it cannot move in the cycle after a pause. Every toggle raises the sticky flag, and the flag falls only after a clear write. The interrupt always equals the flag AND the enable, and the run count stays within bounds and returns to zero after any pause.

Other behaviour is shown only by the bench's scenarios, checked against its reference model. This covers acceptance at exactly the fifth matching strobe and not the fourth, and a run restarting on a differing bit. It also covers a pause breaking a run that was one frame short, and out-of-frame being ignored until its enable is set.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  localparam int CTRL_ADDR    = 0;
  localparam int STAT_ADDR    = 1;
  localparam int CTRL_IEN_BIT = 0;
  localparam int CTRL_OOF_BIT = 1;
  localparam int STAT_CLR_BIT = 0;
  localparam int NUM_HARD_ALM = 5;

  typedef struct packed {
    logic ien;
    logic oof_gate;
  } bdf_ctrl_t;
endpackage

// File: rtl/bdf_pause_gate.sv
module bdf_pause_gate #(
  parameter int NUM_HARD = 5
) (
  input  logic [NUM_HARD-1:0] hard_alm,
  input  logic                oof_alm,
  input  logic                oof_gate_en,
  output logic                pause
);
  logic [NUM_HARD-1:0] alm_seen;

  genvar g;
  generate
    for (g = 0; g < NUM_HARD; g++) begin : g_alm
      assign alm_seen[g] = hard_alm[g];
    end
  endgenerate

  assign pause = (|alm_seen) | (oof_alm & oof_gate_en);
endmodule

// File: rtl/bdf_persist.sv
module bdf_persist #(
  parameter int PERSIST_FRAMES = 5,
  localparam int CW = $clog2(PERSIST_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pause,
  input  logic          frame_stb,
  input  logic          bit_in,
  output logic          live_q,
  output logic          change,
  output logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] CNT_FULL = CW'(PERSIST_FRAMES);

  logic          cand_q, cand_d;
  logic [CW-1:0] cnt_d;
  logic          accept;

  always_comb begin
    cand_d = cand_q;
    cnt_d  = cnt_q;
    if (pause) begin
      cnt_d = '0;
    end else if (frame_stb) begin
      if (cnt_q == '0 || bit_in != cand_q) begin
        cand_d = bit_in;
        cnt_d  = CW'(1);
      end else if (cnt_q < CNT_FULL) begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  assign accept = !pause && frame_stb && (cnt_d == CNT_FULL);
  assign change = accept && (cand_d != live_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= 1'b0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      cand_q <= cand_d;
      cnt_q  <= cnt_d;
      if (accept) live_q <= cand_d;
    end
  end
endmodule

// File: rtl/bdf_regs.sv
module bdf_regs
  import bdf_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              change,
  output bdf_ctrl_t         ctrl_q,
  output logic              sticky_q,
  output logic              irq_q
);
  bdf_ctrl_t ctrl_d;
  logic      sticky_d;
  logic      wr_ctrl, wr_clr;
  logic      unused_wdata;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR)) && reg_wdata[STAT_CLR_BIT];
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.ien      = reg_wdata[CTRL_IEN_BIT];
      ctrl_d.oof_gate = reg_wdata[CTRL_OOF_BIT];
    end
    sticky_d = (sticky_q & ~wr_clr) | change;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      sticky_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      sticky_q <= sticky_d;
      irq_q    <= sticky_d & ctrl_d.ien;
    end
  end
endmodule

// File: rtl/bdf_filter.sv
module bdf_filter
  import bdf_pkg::*;
#(
  parameter int PERSIST_FRAMES = 5,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(PERSIST_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic              bdi_bit,
  input  logic              alm_oof,
  input  logic              alm_lof,
  input  logic              alm_los,
  input  logic              alm_lck,
  input  logic              alm_oci,
  input  logic              alm_ais,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              bdi_live,
  output logic              cos_sticky,
  output logic              cos_irq
);
  bdf_ctrl_t     ctrl;
  logic          pause;
  logic          change;
  logic [CW-1:0] run_cnt;

  bdf_pause_gate #(.NUM_HARD(NUM_HARD_ALM)) u_gate (
    .hard_alm    ({alm_ais, alm_oci, alm_lck, alm_los, alm_lof}),
    .oof_alm     (alm_oof),
    .oof_gate_en (ctrl.oof_gate),
    .pause       (pause)
  );

  bdf_persist #(.PERSIST_FRAMES(PERSIST_FRAMES)) u_persist (
    .clk       (clk),
    .rst       (rst),
    .pause     (pause),
    .frame_stb (frame_stb),
    .bit_in    (bdi_bit),
    .live_q    (bdi_live),
    .change    (change),
    .cnt_q     (run_cnt)
  );

  bdf_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .change    (change),
    .ctrl_q    (ctrl),
    .sticky_q  (cos_sticky),
    .irq_q     (cos_irq)
  );
endmodule

// File: rtl/bdf_filter_chk.sv
module bdf_filter_chk #(
  parameter int PERSIST_FRAMES = 5,
  parameter int ADDR_W = 2,
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_stb,
  input logic              pause,
  input logic              live,
  input logic              sticky,
  input logic              irq,
  input logic              ien,
  input logic [CW-1:0]     cnt,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              clr_bit
);
  // R1
  a_r1_live_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (live != $past(live)) |-> $past(frame_stb && !pause));
  // R3
  a_r3_hold_when_paused: assert property (@(posedge clk) disable iff (rst)
    $past(pause) |-> (live == $past(live)));
  // R4
  a_r4_toggle_sets_sticky: assert property (@(posedge clk) disable iff (rst)
    (live != $past(live)) |-> sticky);
  // R5
  a_r5_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
    ($past(sticky) && !sticky) |-> $past(reg_wr && reg_addr == ADDR_W'(1) && clr_bit));
  // R6
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq == (sticky && ien));
  // R7
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(PERSIST_FRAMES));
  a_r7_pause_clears_count: assert property (@(posedge clk) disable iff (rst)
    $past(pause) |-> (cnt == '0));
endmodule

bind bdf_filter bdf_filter_chk #(
  .PERSIST_FRAMES(PERSIST_FRAMES), .ADDR_W(ADDR_W), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_stb (frame_stb),
  .pause     (pause),
  .live      (bdi_live),
  .sticky    (cos_sticky),
  .irq       (cos_irq),
  .ien       (ctrl.ien),
  .cnt       (run_cnt),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .clr_bit   (reg_wdata[0])
);

// File: tb/bdf_filter_bench.sv
`timescale 1ns/1ps
module bdf_filter_bench;
  localparam int N = 5;
  localparam int AW = 2;
  localparam int DW = 8;

  logic clk = 0;
  logic rst = 1;
  logic frame_stb = 0, bdi_bit = 0;
  logic alm_oof = 0, alm_lof = 0, alm_los = 0, alm_lck = 0, alm_oci = 0, alm_ais = 0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic bdi_live, cos_sticky, cos_irq;

  always #5 clk = ~clk;

  bdf_filter #(.PERSIST_FRAMES(N), .ADDR_W(AW), .DATA_W(DW)) u_bdf_filter (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .bdi_bit(bdi_bit),
    .alm_oof(alm_oof), .alm_lof(alm_lof), .alm_los(alm_los), .alm_lck(alm_lck),
    .alm_oci(alm_oci), .alm_ais(alm_ais), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bdi_live(bdi_live), .cos_sticky(cos_sticky), .cos_irq(cos_irq)
  );

  int checks = 0, fails = 0;
  string tag = "R9";

  // reference model state
  bit m_cand, m_live, m_sticky, m_irq, m_ien, m_oofg;
  int m_run;

  function automatic bit model_pause(bit oof, bit hard, bit oofg);
    return hard || (oof && oofg);
  endfunction

  task automatic model_step(bit stb, bit b, bit [5:0] alm, bit wr, int addr, bit [DW-1:0] d);
    bit p, chg, clr;
    p = model_pause(alm[0], |alm[5:1], m_oofg);
    chg = 0;
    if (p) m_run = 0;
    else if (stb) begin
      if (m_run == 0 || b != m_cand) begin m_cand = b; m_run = 1; end
      else if (m_run < N) m_run++;
      if (m_run == N && m_cand != m_live) begin m_live = m_cand; chg = 1; end
    end
    clr = wr && addr == 1 && d[0];
    if (wr && addr == 0) begin m_ien = d[0]; m_oofg = d[1]; end
    m_sticky = (m_sticky && !clr) || chg;
    m_irq = m_sticky && m_ien;
  endtask

  task automatic check(string t, logic act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(tag, bdi_live, m_live, "bdi_live");
    check(tag, cos_sticky, m_sticky, "cos_sticky");
    check(tag, cos_irq, m_irq, "cos_irq");
  endtask

  // one cycle: drive at negedge, compare after the following posedge
  task automatic cyc(bit stb, bit b, bit [5:0] alm, bit wr = 0, int addr = 0, bit [DW-1:0] d = '0);
    frame_stb = stb; bdi_bit = b;
    {alm_ais, alm_oci, alm_lck, alm_los, alm_lof, alm_oof} = alm;
    reg_wr = wr; reg_addr = AW'(addr); reg_wdata = d;
    model_step(stb, b, alm, wr, addr, d);
    @(negedge clk);
    check_all();
  endtask

  task automatic frames(int n, bit b, bit [5:0] alm = '0);
    for (int i = 0; i < n; i++) begin
      cyc(1, b, alm);
      cyc(0, !b, alm);
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    tag = "R9";
    check_all();
    cyc(0, 0, '0);
    // R1: four strobes of 1 do not change, fifth does; idle gaps do not break the run
    tag = "R1";
    frames(4, 1);
    check("R1", bdi_live, 0, "live after 4 frames");
    cyc(0, 0, '0); cyc(0, 0, '0);
    cyc(1, 1, '0);
    check("R1", bdi_live, 1, "live after 5th frame");
    // R4: toggle raised sticky
    check("R4", cos_sticky, 1, "sticky after toggle");
    // R6: mask off -> no irq; enable -> irq
    check("R6", cos_irq, 0, "irq masked");
    tag = "R6";
    cyc(0, 0, '0, 1, 0, 8'h01);
    check("R6", cos_irq, 1, "irq enabled");
    // R5: wrong address / zero bit do not clear; proper write clears
    tag = "R5";
    cyc(0, 0, '0, 1, 2, 8'h01);
    cyc(0, 0, '0, 1, 1, 8'h02);
    check("R5", cos_sticky, 1, "sticky kept");
    cyc(0, 0, '0, 1, 1, 8'h01);
    check("R5", cos_sticky, 0, "sticky cleared");
    // R2: differing bit restarts run
    tag = "R2";
    frames(3, 0); frames(1, 1); frames(4, 0);
    check("R2", bdi_live, 1, "live after broken run");
    frames(1, 0);
    check("R2", bdi_live, 0, "live after restarted run");
    // R4 set wins over simultaneous clear
    tag = "R4";
    frames(4, 1);
    cyc(1, 1, '0, 1, 1, 8'h01);
    check("R4", cos_sticky, 1, "set beats clear");
    cyc(0, 0, '0, 1, 1, 8'h01);
    // R7: pause one short of acceptance breaks the run; live held
    tag = "R7";
    frames(4, 0);
    frames(3, 0, 6'b000100);
    check("R7", bdi_live, 1, "live held during pause");
    frames(1, 0);
    check("R7", bdi_live, 1, "restart from zero after pause");
    frames(4, 0);
    check("R7", bdi_live, 0, "accepted after fresh run");
    // R8: oof ignored with gate off, pauses with gate on
    tag = "R8";
    frames(5, 1, 6'b000001);
    check("R8", bdi_live, 1, "oof ignored when gate off");
    cyc(0, 0, '0, 1, 0, 8'h03);
    frames(4, 0); frames(2, 0, 6'b000001); frames(1, 0);
    check("R8", bdi_live, 1, "oof pauses when gate on");
    cyc(0, 0, '0, 1, 0, 8'h01);
    // random phase
    tag = "R3";
    begin
      bit b = 0;
      bit [5:0] alm = '0;
      for (int k = 0; k < 6000; k++) begin
        bit stb, wr;
        int addr;
        stb = ($urandom % 3) == 0;
        if (stb && ($urandom % 8) == 0) b = !b;
        for (int j = 0; j < 6; j++) begin
          if ($urandom % 500 == 0) alm[j] = 1'b1;
          else if (alm[j] && $urandom % 12 == 0) alm[j] = 1'b0;
        end
        wr = ($urandom % 40) == 0;
        addr = $urandom % 4;
        cyc(stb, stb ? b : 1'($urandom), alm, wr, addr, 8'($urandom));
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule